// File: doc/BRIEF.md
# Real-Time Periodic Interrupt Generator

This block divides the bus clock into a slow periodic timebase and raises a sticky event flag every time the period runs out. The period is a base count of bus cycles, 2^BASE_LOG2 (8192 by default), multiplied by a power of two chosen through a two-bit rate field. Software reaches the block through a small byte-wide register port. One control register holds the rate field and an interrupt-enable bit. One flag register holds the event flag, which is cleared by writing a one to it.

The period counter runs freely from reset. Clearing the flag does not restart it. Changing the rate does not restart it either. The counter keeps measuring from the last expiry, so the next expiry falls at that expiry plus the new period. The interrupt request output is high while the flag is set and the interrupt is enabled.

Top module: `periodic_irq_gen`

## Requirements
- R1: The period is 2^BASE_LOG2 × 2^rate bus cycles, where rate is control register bits [1:0]. With rate 0 the first expiry falls on the 2^BASE_LOG2-th rising clock edge after reset is released.
- R2: On every expiry, flag register bit 6 becomes 1 in the following cycle and stays 1 until software clears it.
- R3: A write to the flag register (address 1) with bit 6 set clears the flag.
- R4: A write to the flag register with bit 6 at 0 leaves the flag unchanged.
- R5: A write to the control register (address 0) changes the rate without setting the flag. The next expiry then falls at the previous expiry plus the new period. Rate bits [1:0] and enable bit 7 read back as written; all other bits read 0.
- R6: If a rate write selects a period that has already elapsed since the last expiry, the expiry occurs on the clock edge after the write takes effect.
- R7: Reset clears the control register (rate 0, interrupt disabled) and the flag, and restarts the period count.
- R8: irq_o is high exactly when the flag is set and control bit 7 is 1.
- R9: Clearing the flag does not restart the period count.
- R10: If an expiry and a write-one-to-clear of the flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 flag |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the flag in the same cycle: an expiry of the period and a software write-one-to-clear. The bench counts cycles from the last observed expiry and issues the clear so that it commits on the exact edge where the next expiry is due. It then expects the flag to read 1. A second timing corner is a rate write that shortens the period below the time already elapsed. That write is placed at a known offset, and the expiry must appear one edge after the write commits.

// File: rtl/pig_pkg.sv
package pig_pkg;
    localparam int RATE_W      = 2;
    localparam int DATA_W      = 8;
    localparam bit ADDR_CTRL   = 1'b0;
    localparam bit ADDR_FLAG   = 1'b1;
    localparam int EN_BIT      = 7;
    localparam int FLAG_BIT    = 6;
endpackage

// File: rtl/pig_rate_decode.sv
module pig_rate_decode
    import pig_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    localparam int NRATES   = 1 << RATE_W,
    localparam int CW       = BASE_LOG2 + NRATES - 1
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [CW-1:0]     limit_o
);
    logic [CW-1:0] limit_tbl [NRATES];

    for (genvar g = 0; g < NRATES; g++) begin : g_rate
        localparam logic [CW:0] PERIOD = (CW+1)'(1) << (BASE_LOG2 + g);
        assign limit_tbl[g] = CW'(PERIOD - 1);
    end

    assign limit_o = limit_tbl[rate_i];
endmodule

// File: rtl/pig_period_ctr.sv
module pig_period_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] limit_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [CW-1:0] elapsed;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.elapsed >= limit_i);
        if (tick_o) st_d.elapsed = '0;
        else        st_d.elapsed = st_q.elapsed + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R9
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> st_q.elapsed == CW'($past(st_q.elapsed) + 1'b1));
    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> st_q.elapsed == '0);
endmodule

// File: rtl/pig_ctrl_regs.sv
module pig_ctrl_regs
    import pig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_i,
    output logic [DATA_W-1:0] rd_data,
    output logic [RATE_W-1:0] rate_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
        logic              flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_ctrl, wr_flag;

    always_comb begin
        st_d    = st_q;
        wr_ctrl = wr_en && (addr == ADDR_CTRL);
        wr_flag = wr_en && (addr == ADDR_FLAG);
        if (wr_ctrl) begin
            st_d.en   = wr_data[EN_BIT];
            st_d.rate = wr_data[RATE_W-1:0];
        end
        if (wr_flag && wr_data[FLAG_BIT]) st_d.flag = 1'b0;
        if (tick_i)                       st_d.flag = 1'b1;

        rd_data = '0;
        if (addr == ADDR_CTRL) begin
            rd_data[EN_BIT]       = st_q.en;
            rd_data[RATE_W-1:0]   = st_q.rate;
        end else begin
            rd_data[FLAG_BIT]     = st_q.flag;
        end
        rate_o = st_q.rate;
        irq_o  = st_q.flag & st_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2 R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> st_q.flag);
    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_FLAG && wr_data[FLAG_BIT] && !tick_i) |=> !st_q.flag);
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_FLAG && !wr_data[FLAG_BIT] && !tick_i) |=> $stable(st_q.flag));
    // R5
    rate_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_CTRL && !tick_i && !st_q.flag) |=> !st_q.flag);
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pig_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    localparam int CW       = BASE_LOG2 + (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic [RATE_W-1:0] rate;
    logic [CW-1:0]     limit;
    logic              tick;

    pig_rate_decode #(.BASE_LOG2(BASE_LOG2)) u_decode (
        .rate_i (rate),
        .limit_o(limit)
    );

    pig_period_ctr #(.CW(CW)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .limit_i(limit),
        .tick_o (tick)
    );

    pig_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .tick_i (tick),
        .rd_data(rd_data),
        .rate_o (rate),
        .irq_o  (irq_o)
    );

    // R7
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (rate == '0) && !irq_o);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_CTRL && !wr_data[EN_BIT]) |=> !irq_o);
endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
    localparam int B = 4;
    localparam int NV = 4;
    // each entry: {rate, expected period}
    localparam logic [1:0] VRATE [NV] = '{2'd1, 2'd3, 2'd0, 2'd2};
    localparam int         VPER  [NV] = '{32, 128, 16, 64};

    logic clk = 0, rst = 1, wr_en = 0, addr = 1;
    logic [7:0] wr_data = 0, rd_data;
    logic irq_o;
    int cyc = 0, checks = 0, errors = 0, t_last = 0;
    bit done = 0;

    periodic_irq_gen #(.BASE_LOG2(B)) dut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        wr_en = 1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; addr = 1; wr_data = 0;
        @(negedge clk);
    endtask

    function automatic int rd_flag(); return int'(rd_data[6]); endfunction

    task automatic read_ctrl(output int v);
        addr = 0; #1; v = int'(rd_data); addr = 1; #1;
    endtask

    task automatic poll_flag();
        for (int i = 0; i < 400 && rd_flag() == 0; i++) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        for (int i = 0; i < 400 && cyc < c; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R7 reset state
        read_ctrl(v);
        chk("R7 ctrl after reset", v, 0);
        chk("R7 flag after reset", rd_flag(), 0);
        chk("R7 irq after reset", int'(irq_o), 0);
        // R1 first expiry at 2^B
        poll_flag();
        chk("R1 first expiry cycle", cyc, 16);
        chk("R2 flag set", rd_flag(), 1);
        chk("R8 irq off while disabled", int'(irq_o), 0);
        t_last = cyc;
        // R4 write zero keeps flag
        do_write(1, 8'h00);
        chk("R4 flag kept", rd_flag(), 1);
        // R3 write one clears
        do_write(1, 8'h40);
        chk("R3 flag cleared", rd_flag(), 0);
        // R9 clear did not restart the count
        poll_flag();
        chk("R9 next expiry after clear", cyc - t_last, 16);
        t_last = cyc;
        // R5 vector walk over rates
        for (int k = 0; k < NV; k++) begin
            do_write(1, 8'h40);
            do_write(0, {6'd0, VRATE[k]});
            chk("R5 rate write no flag", rd_flag(), 0);
            read_ctrl(v);
            chk("R5 rate readback", v, int'(VRATE[k]));
            poll_flag();
            chk("R5 R1 period after rate write", cyc - t_last, VPER[k]);
            t_last = cyc;
        end
        // R10 collision: clear commits on the expiry edge (rate 2, period 64)
        do_write(1, 8'h40);
        wait_until(t_last + 63);
        do_write(1, 8'h40);
        chk("R10 set wins over clear", rd_flag(), 1);
        chk("R10 collision cycle", cyc, t_last + 64);
        t_last = t_last + 64;
        // R6 shorten period below elapsed time
        do_write(1, 8'h40);
        do_write(0, 8'h83);
        chk("R8 irq low with flag clear", int'(irq_o), 0);
        wait_until(t_last + 40);
        do_write(0, 8'h80);
        poll_flag();
        chk("R6 immediate expiry", cyc, t_last + 42);
        chk("R8 irq high when flag and enable", int'(irq_o), 1);
        do_write(1, 8'h40);
        chk("R8 irq drops after clear", int'(irq_o), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule